// File: doc/BRIEF.md
# Endpoint List Service Scheduler

This block sits beside the descriptor fetch engine of a USB host controller and decides, once per descriptor, which endpoint-descriptor list gets served next: the periodic list, the control list, the bulk list, or nothing. It watches the frame start pulse, a level that marks the part of the frame reserved for periodic traffic, a non-empty flag for each list, a pulse saying the current descriptor is finished, and a flag saying the descriptor now being handled is isochronous. Software settings come in as plain inputs: a 2-bit control-to-bulk weight and four list enables.

Periodic traffic goes first while its window is open. Control and bulk then share the remaining time by a weighted round. A run of control descriptors is followed by one bulk descriptor, and the run length is set by the weight. The count of control descriptors served is kept across frame boundaries. The periodic and isochronous enables are captured at each frame start, so a change made by software takes effect only in the following frame. If an isochronous descriptor turns up while isochronous service is off, the periodic list is abandoned for the rest of that frame.

Top module: `ed_list_sched`

## Requirements
- R1: Synchronous reset (`rst` high) drives `grant` to idle (4'b1000) and clears the control-served count. The periodic and isochronous enables are captured from their inputs during reset, so the first decision after reset grants periodic if its window is open, its list is non-empty and `per_on` is high.
- R2: `grant` is one-hot: bit 0 periodic, bit 1 control, bit 2 bulk, bit 3 idle.
- R3: `grant` changes only at a decision edge. A decision edge is a clock edge with `ed_done` high, with `frame_start` high, or with an isochronous stop (R6). It is also any clock edge while `grant` is idle. Otherwise `grant` holds.
- R4: At a decision, periodic is granted when `per_window` is high, `per_ready` is high, the captured periodic enable is set and the periodic list has not been stopped in this frame.
- R5: `per_on` is captured at each `frame_start`. A decision taken at a frame start edge already uses the new value. A change between frame starts has no effect until the next one.
- R6: With periodic granted, if `ed_iso` is high while the captured isochronous enable is clear, that edge becomes a decision that excludes periodic. Periodic is then not granted again until the next `frame_start`.
- R7: `iso_on` is captured at each `frame_start`. A change in the middle of a frame does not alter that frame.
- R8: With weight value r on `ratio` (00, 01, 10, 11) and both control and bulk available, r+1 control grants are followed by one bulk grant, repeating.
- R9: The control-served count is not cleared by `frame_start`.
- R10: Control is available only when `ctl_on` and `ctl_ready` are both high, and bulk only when `blk_on` and `blk_ready` are both high. If the preferred list is unavailable, the other one is granted. If neither is available, the grant is idle.
- R11: A bulk grant clears the control-served count. Each control grant increments it, saturating at 2**RATIO_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| per_window | input | 1 | High while periodic service is allowed in this frame |
| per_ready | input | 1 | Periodic list is non-empty |
| ctl_ready | input | 1 | Control list is non-empty |
| blk_ready | input | 1 | Bulk list is non-empty |
| ed_done | input | 1 | One-cycle pulse when the current descriptor is finished |
| ed_iso | input | 1 | The descriptor being handled is isochronous |
| ratio | input | RATIO_W | Control-to-bulk weight, value r gives r+1 to 1 |
| per_on | input | 1 | Periodic list enable |
| iso_on | input | 1 | Isochronous descriptor enable |
| ctl_on | input | 1 | Control list enable |
| blk_on | input | 1 | Bulk list enable |
| grant | output | 4 | One-hot list grant to the fetch engine |

## Verification
The hard coincidence is a frame start landing in the same cycle as a descriptor completion. At that edge the captured periodic enable changes, the periodic stop is cleared, and a selection is made. The selection must already use the new frame's settings, and the control-served count must stay as it was. The bench raises `frame_start` and `ed_done` together just after turning `per_on` on mid-frame, and expects a periodic grant at that very edge. One completion earlier, with the same setting, it expects the previous frame's non-periodic service to continue.

// File: rtl/ed_list_sched.sv
module ed_list_sched #(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic               per_window,
  input  logic               per_ready,
  input  logic               ctl_ready,
  input  logic               blk_ready,
  input  logic               ed_done,
  input  logic               ed_iso,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               per_on,
  input  logic               iso_on,
  input  logic               ctl_on,
  input  logic               blk_on,
  output logic [3:0]         grant
);
  localparam int CNT_W = RATIO_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1) << RATIO_W;
  localparam logic [3:0] G_PER  = 4'b0001;
  localparam logic [3:0] G_CTL  = 4'b0010;
  localparam logic [3:0] G_BLK  = 4'b0100;
  localparam logic [3:0] G_IDLE = 4'b1000;

  logic             per_q, iso_q, stop_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [3:0]       grant_q, pick;

  wire iso_hit  = grant_q[0] & ed_iso & ~iso_q;
  wire decide   = frame_start | ed_done | iso_hit | grant_q[3];
  wire per_f    = frame_start ? per_on : per_q;
  wire stop_f   = frame_start ? 1'b0 : (stop_q | iso_hit);
  wire per_ok   = per_window & per_ready & per_f & ~stop_f;
  wire ctl_ok   = ctl_on & ctl_ready;
  wire blk_ok   = blk_on & blk_ready;
  wire want_ctl = cnt_q <= {1'b0, ratio};

  always_comb begin
    if (per_ok)        pick = G_PER;
    else if (want_ctl) pick = ctl_ok ? G_CTL : (blk_ok ? G_BLK : G_IDLE);
    else               pick = blk_ok ? G_BLK : (ctl_ok ? G_CTL : G_IDLE);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (pick == G_BLK)
      cnt_d = '0;
    else if (pick == G_CTL && cnt_q != CNT_MAX)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= G_IDLE;
      cnt_q   <= '0;
      stop_q  <= 1'b0;
      per_q   <= per_on;
      iso_q   <= iso_on;
    end else begin
      stop_q <= stop_f;
      if (frame_start) begin
        per_q <= per_on;
        iso_q <= iso_on;
      end
      if (decide) begin
        grant_q <= pick;
        cnt_q   <= cnt_d;
      end
    end
  end

  assign grant = grant_q;
endmodule

// File: rtl/ed_list_sched_chk.sv
module ed_list_sched_chk #(
  parameter int RATIO_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_start,
  input logic               ed_done,
  input logic               ed_iso,
  input logic               ctl_on,
  input logic               ctl_ready,
  input logic [3:0]         grant,
  input logic [RATIO_W:0]   cnt_q,
  input logic               per_q,
  input logic               stop_q
);
  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(grant) == 1);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !ed_done && !ed_iso && !grant[3]) |=> $stable(grant));

  assert_per_enabled_R5: assert property (@(posedge clk) disable iff (rst)
    grant[0] |-> per_q);

  assert_stop_excludes_R6: assert property (@(posedge clk) disable iff (rst)
    stop_q |-> !grant[0]);

  assert_ctl_avail_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(grant[1]) |-> $past(ctl_on && ctl_ready));

  assert_bulk_clears_R11: assert property (@(posedge clk) disable iff (rst)
    grant[2] |-> cnt_q == '0);

  assert_cnt_range_R11: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= (RATIO_W + 1)'(1 << RATIO_W));

  assert_ctl_counted_R8: assert property (@(posedge clk) disable iff (rst)
    grant[1] |-> cnt_q != '0);
endmodule

bind ed_list_sched ed_list_sched_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .ed_done(ed_done),
  .ed_iso(ed_iso), .ctl_on(ctl_on), .ctl_ready(ctl_ready), .grant(grant),
  .cnt_q(cnt_q), .per_q(per_q), .stop_q(stop_q)
);

// File: tb/test_ed_list_sched.sv
module test_ed_list_sched;
  localparam logic [3:0] P = 4'b0001, C = 4'b0010, B = 4'b0100, I = 4'b1000;

  logic clk = 0, rst = 1;
  logic frame_start = 0, per_window = 0, per_ready = 0, ctl_ready = 0, blk_ready = 0;
  logic ed_done = 0, ed_iso = 0, per_on = 0, iso_on = 0, ctl_on = 0, blk_on = 0;
  logic [1:0] ratio = 0;
  logic [3:0] grant;
  int n_chk = 0, n_bad = 0;

  ed_list_sched #(.RATIO_W(2)) i_ed_list_sched (
    .clk(clk), .rst(rst), .frame_start(frame_start), .per_window(per_window),
    .per_ready(per_ready), .ctl_ready(ctl_ready), .blk_ready(blk_ready),
    .ed_done(ed_done), .ed_iso(ed_iso), .ratio(ratio), .per_on(per_on),
    .iso_on(iso_on), .ctl_on(ctl_on), .blk_on(blk_on), .grant(grant));

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    n_chk++;
    if (grant !== exp) begin
      n_bad++;
      $display("FAIL %s grant=%b expected=%b", req, grant, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic done_pulse();
    ed_done = 1; tick(); ed_done = 0;
  endtask

  task automatic sof_pulse();
    frame_start = 1; tick(); frame_start = 0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog grant=%b expected=progress", grant);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    ctl_on = 1; ctl_ready = 1; blk_on = 1; blk_ready = 1;
    do_reset(); rst = 1; tick();
    check("R1 reset idle", I);
    rst = 0;

    // R8 R2: weighted round for every ratio value
    for (int r = 0; r < 4; r++) begin
      ratio = 2'(r);
      do_reset(); tick();
      check("R8 first", C);
      for (int i = 1; i < 12; i++) begin
        done_pulse();
        check("R8 R2 round", ((i % (r + 2)) == r + 1) ? B : C);
      end
    end

    // R10: availability sweep, control preferred
    ratio = 0;
    for (int c = 0; c < 16; c++) begin
      ctl_on = 1; ctl_ready = 1; blk_on = 1; blk_ready = 1;
      ctl_on = c[0]; ctl_ready = c[1]; blk_on = c[2]; blk_ready = c[3];
      do_reset(); tick();
      check("R10 ctl preferred", (c[0] && c[1]) ? C : ((c[2] && c[3]) ? B : I));
    end

    // R10: availability sweep, bulk preferred
    for (int c = 0; c < 16; c++) begin
      ctl_on = 1; ctl_ready = 1; blk_on = 1; blk_ready = 1;
      do_reset(); tick();
      ctl_on = c[0]; ctl_ready = c[1]; blk_on = c[2]; blk_ready = c[3];
      done_pulse();
      check("R10 blk preferred", (c[2] && c[3]) ? B : ((c[0] && c[1]) ? C : I));
    end

    // R3: grant held without a decision edge
    ctl_on = 1; ctl_ready = 1; blk_on = 1; blk_ready = 1;
    do_reset(); tick();
    repeat (5) tick();
    check("R3 hold", C);

    // R9 R11: count survives frame start, bulk clears it
    ratio = 3;
    do_reset(); tick();
    done_pulse();
    sof_pulse();
    check("R9 sof decision", C);
    done_pulse();
    check("R9 fourth control", C);
    done_pulse();
    check("R9 bulk after four", B);
    done_pulse();
    check("R11 restart after bulk", C);

    // R1 R4: periodic first after reset
    per_on = 1; per_window = 1; per_ready = 1;
    do_reset(); tick();
    check("R1 periodic first", P);
    done_pulse();
    check("R4 periodic priority", P);
    per_window = 0;
    done_pulse();
    check("R4 window closed", C);
    per_window = 1;

    // R5: periodic enable captured at frame start
    per_on = 0;
    do_reset(); tick();
    check("R5 disabled at reset", C);
    per_on = 1;
    done_pulse();
    check("R5 mid-frame no effect", C);
    frame_start = 1; ed_done = 1; tick(); frame_start = 0; ed_done = 0;
    check("R5 sof with done", P);
    per_on = 0;
    done_pulse();
    check("R5 still latched", P);
    sof_pulse();
    check("R5 cleared at sof", C);

    // R6 R7: isochronous stop
    per_on = 1; iso_on = 0;
    do_reset(); tick();
    check("R6 periodic start", P);
    iso_on = 1;
    ed_iso = 1; tick(); ed_iso = 0;
    check("R6 R7 iso stop", C);
    done_pulse();
    check("R6 stopped in frame", C);
    sof_pulse();
    check("R6 resumed at sof", P);
    ed_iso = 1; tick(); ed_iso = 0;
    check("R7 iso enabled next frame", P);
    done_pulse();
    check("R7 continue periodic", P);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule